// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This block powers up a smart card contact interface in a fixed order once the host asks for a session. A session request is a card-present flag together with an active-low power request. When the block accepts a request it switches the oscillator to its fast rate. It then steps through the rest of the activation: it enables the voltage generator, reports the end of the supply ramp, enables the I/O and auxiliary lines, gates the card clock on and releases the card reset.

All event times are counted in oscillator ticks (`osc_tick_i`, a one-cycle enable). The base unit is `T_UNIT` ticks, 64 by default. The host reset input decides when the card clock starts. If it is low when the session starts, the clock runs shortly after the I/O lines are enabled. If it is high, the clock waits until the host pulls it low. After the last event the card reset follows the host reset input, and an active status is shown for as long as the session is held.

Top module: `sc_act_seq`

## Requirements
- R1: After reset, and whenever `card_pres_i` is low or `pwr_req_ni` is high, every output is 0.
- R2: On the first clock edge where `card_pres_i`=1 and `pwr_req_ni`=0 while idle (instant t0), `hf_osc_o` rises and stays high for the session; ticks at that edge are not counted.
- R3: `vgen_en_o` rises once `T_UNIT` ticks have been counted after t0 (instant t1).
- R4: `vcc_ok_o` rises once t1 + 1.5·`T_UNIT` ticks are reached.
- R5: `io_en_o` rises once t1 + 4·`T_UNIT` ticks are reached (t3).
- R6: When `host_rst_i` was 0 at t0, `clk_en_o` rises `CLK_GAP` ticks after t3.
- R7: When `host_rst_i` was 1 at t0, `clk_en_o` stays low until `host_rst_i` is seen low after t1, and never before t3 + `CLK_GAP`. If the host never drops it, the clock starts at t5.
- R8: `card_rst_o` is 0 before t5 = t1 + 7·`T_UNIT`; from t5 on it equals `host_rst_i`.
- R9: `active_o` is 1 from t5 for as long as the request is held.
- R10: Dropping `card_pres_i` or raising `pwr_req_ni` at any point in a session returns all outputs to 0 on the next clock edge. A new request starts again from t0.
- R11: From t5 on, `clk_en_o` stays 1 whatever `host_rst_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle oscillator tick |
| card_pres_i | input | 1 | Card present flag |
| pwr_req_ni | input | 1 | Host power request, active low |
| host_rst_i | input | 1 | Host reset input |
| hf_osc_o | output | 1 | Oscillator fast-rate select |
| vgen_en_o | output | 1 | Voltage generator enable |
| vcc_ok_o | output | 1 | Supply ramp complete |
| io_en_o | output | 1 | I/O and auxiliary line enable |
| clk_en_o | output | 1 | Card clock gate |
| card_rst_o | output | 1 | Card reset |
| active_o | output | 1 | Active mode status |

## Verification
The sessions vary in tick density, from a tick every cycle to sparse random ticks. This shows whether event times are counted in ticks rather than in clock cycles. Sessions that start with the host reset high are given drop times before t3, inside the t3–t5 window, or no drop at all. These three cases separate the early-release, window-release and forced-at-t5 clock paths. Aborts at random tick counts and host reset toggling after t5 exercise the return to idle and the reset pass-through. One directed run with a tick every cycle measures the exact cycle distance between events.

// File: rtl/sc_act_pkg.sv
package sc_act_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAKE, ST_RUN} act_st_e;

  function automatic int t2_of(int t); return t + t / 2; endfunction
  function automatic int t3_of(int t); return 4 * t;     endfunction
  function automatic int t5_of(int t); return 7 * t;     endfunction
endpackage

// File: rtl/sc_act_timer.sv
module sc_act_timer
  import sc_act_pkg::*;
#(
  parameter int T_UNIT = 64,
  localparam int T5    = t5_of(T_UNIT),
  localparam int CW    = $clog2(T5 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  output act_st_e       st_o,
  output logic [CW-1:0] cnt_o
);
  act_st_e       st_q;
  logic [CW-1:0] cnt_q;

  // wake phase counts t0->t1, run phase counts from t1 and saturates at t5
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (req_i) st_q <= ST_WAKE;
        end
        ST_WAKE: begin
          if (!req_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (tick_i) begin
            if (cnt_q == CW'(T_UNIT - 1)) begin
              st_q  <= ST_RUN;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (!req_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (tick_i && cnt_q != CW'(T5)) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign st_o  = st_q;
  assign cnt_o = cnt_q;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i) |=> (st_q == ST_WAKE));
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !req_i) |=> (st_q == ST_IDLE));
  p_no_tick_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && req_i && !tick_i) |=> ($stable(cnt_q) && $stable(st_q)));
endmodule

// File: rtl/sc_act_clkctl.sv
module sc_act_clkctl
  import sc_act_pkg::*;
#(
  parameter int T_UNIT  = 64,
  parameter int CLK_GAP = 1,
  localparam int T3     = t3_of(T_UNIT),
  localparam int T5     = t5_of(T_UNIT),
  localparam int CW     = $clog2(T5 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          host_rst_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clk_en_o
);
  logic hold_q, rel_q;
  logic past_gap, at_t5;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      rel_q  <= 1'b0;
    end else if (start_i) begin
      hold_q <= host_rst_i;
      rel_q  <= 1'b0;
    end else if (run_i && hold_q && !host_rst_i) begin
      rel_q  <= 1'b1;
    end
  end

  assign past_gap = cnt_i >= CW'(T3 + CLK_GAP);
  assign at_t5    = cnt_i == CW'(T5);
  // held clock is forced on at t5 even without a host release
  assign clk_en_o = run_i && past_gap && (!hold_q || rel_q || at_t5);

  p_rel_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_q && !start_i) |=> rel_q);
  p_hold_until_rel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && hold_q) |-> (rel_q || at_t5));
endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq
  import sc_act_pkg::*;
#(
  parameter int T_UNIT  = 64,
  parameter int CLK_GAP = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic card_pres_i,
  input  logic pwr_req_ni,
  input  logic host_rst_i,
  output logic hf_osc_o,
  output logic vgen_en_o,
  output logic vcc_ok_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic card_rst_o,
  output logic active_o
);
  localparam int T2 = t2_of(T_UNIT);
  localparam int T3 = t3_of(T_UNIT);
  localparam int T5 = t5_of(T_UNIT);
  localparam int CW = $clog2(T5 + 1);

  logic          req, run, start, at_t5;
  act_st_e       st;
  logic [CW-1:0] cnt;

  assign req   = card_pres_i & ~pwr_req_ni;
  assign run   = st == ST_RUN;
  assign start = (st == ST_IDLE) && req;

  sc_act_timer #(.T_UNIT(T_UNIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (osc_tick_i),
    .req_i  (req),
    .st_o   (st),
    .cnt_o  (cnt)
  );

  sc_act_clkctl #(.T_UNIT(T_UNIT), .CLK_GAP(CLK_GAP)) u_clkctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .run_i      (run),
    .host_rst_i (host_rst_i),
    .cnt_i      (cnt),
    .clk_en_o   (clk_en_o)
  );

  assign at_t5      = run && (cnt == CW'(T5));
  assign hf_osc_o   = st != ST_IDLE;
  assign vgen_en_o  = run;
  assign vcc_ok_o   = run && (cnt >= CW'(T2));
  assign io_en_o    = run && (cnt >= CW'(T3));
  assign active_o   = at_t5;
  assign card_rst_o = at_t5 & host_rst_i;

  p_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> (vcc_ok_o && vgen_en_o && hf_osc_o));
  p_clk_after_io_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> io_en_o);
  p_rst_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !card_rst_o);
  p_clk_at_t5_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> clk_en_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |=> !hf_osc_o);
endmodule

// File: tb/sc_act_seq_test.sv
`timescale 1ns/1ps
module sc_act_seq_test;
  localparam int T  = 64;
  localparam int GP = 1;
  localparam int E2 = T + T + T / 2;
  localparam int E3 = T + 4 * T;
  localparam int E5 = T + 7 * T;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, pres = 1'b0, pwr_n = 1'b1, host = 1'b0;
  logic hf, vgen, vcc, io, cke, crst, act;
  int   errors = 0, checks = 0, cyc = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  sc_act_seq #(.T_UNIT(T), .CLK_GAP(GP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .card_pres_i(pres),
    .pwr_req_ni(pwr_n), .host_rst_i(host), .hf_osc_o(hf), .vgen_en_o(vgen),
    .vcc_ok_o(vcc), .io_en_o(io), .clk_en_o(cke), .card_rst_o(crst), .active_o(act)
  );

  // reference model built from the requirements: ticks counted from t0
  bit m_act, m_hold, m_rel;
  int m_ticks;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_ticks <= 0; m_hold <= 0; m_rel <= 0;
    end else if (!m_act) begin
      if (pres && !pwr_n) begin
        m_act <= 1; m_ticks <= 0; m_hold <= host; m_rel <= 0;
      end
    end else if (!(pres && !pwr_n)) begin
      m_act <= 0; m_ticks <= 0;
    end else begin
      if (m_ticks >= T && m_hold && !host) m_rel <= 1;
      if (tick && m_ticks < E5) m_ticks <= m_ticks + 1;
    end
  end

  function automatic bit e_clk();
    return m_act && m_ticks >= E3 + GP && (!m_hold || m_rel || m_ticks >= E5);
  endfunction

  task automatic chk(string tag, logic a, logic e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, a, e);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (!rst_n) begin
      chk("R1 reset", |{hf, vgen, vcc, io, cke, crst, act}, 1'b0);
    end else begin
      chk("R1/R2 hf_osc", hf, m_act);
      chk("R3 vgen_en", vgen, m_act && m_ticks >= T);
      chk("R4 vcc_ok", vcc, m_act && m_ticks >= E2);
      chk("R5 io_en", io, m_act && m_ticks >= E3);
      chk("R6/R7/R11 clk_en", cke, e_clk());
      chk("R8 card_rst", crst, m_act && m_ticks >= E5 && host);
      chk("R9 active", act, m_act && m_ticks >= E5);
    end
  endtask

  // hs: host reset at t0; drop: tick count where host drops (-1 never)
  // ab: tick count to abort at (-1 none); tp: tick percentage
  task automatic session(bit hs, int drop, int ab, int tp);
    host = hs; pres = 1; pwr_n = 0;
    for (int i = 0; i < 20000; i++) begin
      cycle();
      tick = ($urandom % 100) < tp;
      if (hs && drop >= 0 && m_act && m_ticks >= drop) host = 0;
      if (ab >= 0 && m_act && m_ticks >= ab) begin
        if ($urandom % 2) pres = 0; else pwr_n = 1;
        cycle(); cycle();
        chk("R10 abort idle", |{hf, vgen, vcc, io, cke, crst, act}, 1'b0);
        break;
      end
      if (m_act && m_ticks >= E5) begin
        for (int k = 0; k < 40; k++) begin
          cycle();
          host = $urandom % 2;  // R8 pass-through, R11 clock unaffected
          tick = $urandom % 2;
        end
        break;
      end
    end
    pwr_n = 1; tick = 0;
    cycle(); cycle();
    chk("R10 release idle", |{hf, vgen, vcc, io, cke, crst, act}, 1'b0);
    pres = 0; host = 0;
    cycle();
  endtask

  initial begin
    int c_hf, c_vg, c_vc, c_io, c_ck, c_ac;
    process::self().srandom(32'h5C0A_1234);
    repeat (3) cycle();
    rst_n = 1;
    cycle();
    // R1: partial requests never start
    pres = 0; pwr_n = 0; tick = 1;
    repeat (20) cycle();
    pres = 1; pwr_n = 1;
    repeat (20) cycle();
    chk("R1 no start", hf, 1'b0);
    pres = 0; tick = 0;
    cycle();

    // directed exact timing, tick every cycle, no hold
    c_hf = -1; c_vg = -1; c_vc = -1; c_io = -1; c_ck = -1; c_ac = -1;
    tick = 1; host = 0; pres = 1; pwr_n = 0;
    for (int i = 0; i < 700; i++) begin
      cycle();
      if (hf   && c_hf < 0) c_hf = cyc;
      if (vgen && c_vg < 0) c_vg = cyc;
      if (vcc  && c_vc < 0) c_vc = cyc;
      if (io   && c_io < 0) c_io = cyc;
      if (cke  && c_ck < 0) c_ck = cyc;
      if (act  && c_ac < 0) c_ac = cyc;
    end
    chk("R3 t1 distance", c_vg - c_hf == T, 1'b1);
    chk("R4 t2 distance", c_vc - c_vg == T + T / 2, 1'b1);
    chk("R5 t3 distance", c_io - c_vg == 4 * T, 1'b1);
    chk("R6 clk gap", c_ck - c_io == GP, 1'b1);
    chk("R9 t5 distance", c_ac - c_vg == 7 * T, 1'b1);
    pwr_n = 1; tick = 0;
    cycle(); cycle();
    pres = 0;
    cycle();

    // directed hold paths
    session(1'b1, E3 + 40, -1, 100);  // drop inside window, R7
    session(1'b1, T / 2, -1, 70);     // early drop, R7
    session(1'b1, -1, -1, 60);        // never dropped: forced at t5, R7
    session(1'b1, E5 - 1, -1, 100);   // drop at window edge, R7
    session(1'b0, -1, 0, 100);        // abort at t0, R10
    session(1'b0, -1, E5 - 2, 50);    // late abort, R10

    // random sessions
    for (int s = 0; s < 24; s++) begin
      bit hs = $urandom % 2;
      int dr = (($urandom % 4) == 0) ? -1 : int'($urandom % (E5 + 8));
      int ab = (($urandom % 3) == 0) ? int'($urandom % (E5 + 1)) : -1;
      int tp = 20 + int'($urandom % 81);
      session(hs, dr, ab, tp);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule